// File: doc/BRIEF.md
# Debug Breakpoint Address Matcher

This block watches a processor's instruction fetches and data accesses and compares each one against a set of programmable breakpoint slots (four by default). Each slot holds a linear address, a 2-bit type code, a 2-bit length code and an enable bit. A slot of type execute matches only a fetch whose address is exactly the slot address. A data slot matches a sized data access when any byte of the access falls inside the slot's naturally aligned window of 1, 2 or 4 bytes.

Execute matches raise a fault request in the cycle after the fetch is presented, so the pipeline can stop before the instruction runs. Data matches are held as pending until the completion strobe reports that the transfer has finished, and only then raise a trap request. A sticky per-slot status vector records every match, including matches on disabled slots, until software clears it.

The configuration arrives on flat ports from a register bank outside this block. Exception delivery, the pipeline and privilege handling sit elsewhere.

Top module: `dbg_bkpt_match`

## Requirements
- R1: While reset is asserted and in the first cycle after it, fault_req, trap_req and hit_status are all zero.
- R2: A slot with type 00 and length 00 matches a fetch (acc_kind 00) only when acc_addr equals the slot address exactly; fault_req goes high for one cycle in the cycle after the fetch is presented and the slot's hit_status bit is set in that same cycle.
- R3: A slot with type 00 and any length other than 00 never matches anything.
- R4: For a data slot, length 00 covers 1 byte, 01 covers 2 bytes and 11 covers 4 bytes, the window starting at the slot address with its low 0, 1 or 2 bits cleared; length 10 never matches.
- R5: A data access covers the bytes acc_addr through acc_addr+acc_size (acc_size is the byte count minus one) and hits a data slot when any of those bytes lies in the window; byte addresses do not wrap past the top of the address space.
- R6: Type 01 matches writes (acc_kind 01) only, type 11 matches reads (acc_kind 10) and writes, type 10 never matches; fetches never hit data slots and data accesses never hit execute slots.
- R7: trap_req goes high for one cycle in the cycle after acc_done is sampled high while a data access is pending or presented in that same cycle; a data access stays pending until acc_done, and a newer data access replaces the pending one.
- R8: fault_req or trap_req is raised only when at least one matching slot is enabled; hit_status bits are set on a match whether or not the slot is enabled.
- R9: A hit_status bit stays set until a cycle in which the matching hit_clr bit is high; a new match in the same cycle as a clear leaves the bit set.
- R10: An access presented with acc_kind 11 is ignored: no request and no status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | NS*AW | Slot addresses, slot i in bits [i*AW +: AW] |
| cfg_type | input | 2*NS | Slot type codes, slot i in bits [2i +: 2] |
| cfg_len | input | 2*NS | Slot length codes, slot i in bits [2i +: 2] |
| cfg_en | input | NS | Per-slot enable |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 00 fetch, 01 write, 10 read, 11 none |
| acc_addr | input | AW | First byte address of the access |
| acc_size | input | 2 | Byte count minus one |
| acc_done | input | 1 | The pending data transfer has completed |
| hit_clr | input | NS | Per-slot clear of hit_status |
| fault_req | output | 1 | Execute breakpoint fault request |
| trap_req | output | 1 | Data breakpoint trap request |
| hit_status | output | NS | Sticky per-slot match record |

## Verification
The bench aims at accesses that straddle a window edge by one byte, where a design comparing only start addresses would miss the hit, and at fetches one byte past an execute address, where a masked compare would falsely fault. It covers an access at the very top of the address space against a window at address zero, which catches an adder that wraps, and the reserved type and length codes, which a loose decoder would let through. It stretches the gap between access and completion and replaces a pending access before completion, so a design that traps early or keeps the stale mask is reported, and it clears status in the same cycle as a new match to catch a clear that wins.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_READ  = 2'b10,
        ACC_NONE  = 2'b11
    } acc_kind_e;

    localparam logic [1:0] BP_EXEC = 2'b00;
    localparam logic [1:0] BP_WR   = 2'b01;
    localparam logic [1:0] BP_RW   = 2'b11;

    localparam logic [1:0] LEN_1 = 2'b00;
    localparam logic [1:0] LEN_2 = 2'b01;
    localparam logic [1:0] LEN_4 = 2'b11;

endpackage

// File: rtl/bkpt_slot_cmp.sv
module bkpt_slot_cmp
    import bkpt_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] bp_addr,
    input  logic [1:0]    bp_type,
    input  logic [1:0]    bp_len,
    input  logic [1:0]    acc_kind,
    input  logic [AW-1:0] acc_addr,
    input  logic [1:0]    acc_size,
    output logic          exec_hit,
    output logic          data_hit
);

    localparam int XW = AW + 1;

    logic [1:0]    lo_bits;
    logic          len_ok;
    logic          type_ok;
    logic [AW-1:0] win_base;
    logic [XW-1:0] win_last;
    logic [XW-1:0] acc_first;
    logic [XW-1:0] acc_last;
    logic          overlap;

    always_comb begin
        case (bp_len)
            LEN_1:   begin lo_bits = 2'b00; len_ok = 1'b1; end
            LEN_2:   begin lo_bits = 2'b01; len_ok = 1'b1; end
            LEN_4:   begin lo_bits = 2'b11; len_ok = 1'b1; end
            default: begin lo_bits = 2'b00; len_ok = 1'b0; end
        endcase

        win_base  = bp_addr & ~{{(AW-2){1'b0}}, lo_bits};
        win_last  = {1'b0, win_base} + {{(XW-2){1'b0}}, lo_bits};
        acc_first = {1'b0, acc_addr};
        acc_last  = acc_first + {{(XW-2){1'b0}}, acc_size};
        overlap   = (acc_first <= win_last) && ({1'b0, win_base} <= acc_last);

        case (acc_kind)
            ACC_WRITE: type_ok = (bp_type == BP_WR) || (bp_type == BP_RW);
            ACC_READ:  type_ok = (bp_type == BP_RW);
            default:   type_ok = 1'b0;
        endcase

        data_hit = len_ok && type_ok && overlap;
        exec_hit = (acc_kind == ACC_FETCH) && (bp_type == BP_EXEC)
                && (bp_len == LEN_1) && (acc_addr == bp_addr);
    end

    always_comb begin
        a_r6_exec_data_exclusive: assert (!(exec_hit && data_hit));
    end

endmodule

// File: rtl/bkpt_seq.sv
module bkpt_seq
    import bkpt_pkg::*;
#(
    parameter int NS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic [1:0]    acc_kind,
    input  logic          acc_done,
    input  logic [NS-1:0] exec_mask,
    input  logic [NS-1:0] data_mask,
    input  logic [NS-1:0] slot_en,
    input  logic [NS-1:0] hit_clr,
    output logic          fault_req,
    output logic          trap_req,
    output logic [NS-1:0] hit_status
);

    typedef struct packed {
        logic          pend_vld;
        logic [NS-1:0] pend_mask;
        logic          fault;
        logic          trap;
        logic [NS-1:0] status;
    } seq_t;

    seq_t st_d, st_q;

    logic          is_fetch;
    logic          is_data;
    logic          eff_vld;
    logic [NS-1:0] eff_mask;

    always_comb begin
        st_d       = st_q;
        st_d.fault = 1'b0;
        st_d.trap  = 1'b0;
        st_d.status = st_q.status & ~hit_clr;

        is_fetch = acc_valid && (acc_kind == ACC_FETCH);
        is_data  = acc_valid && ((acc_kind == ACC_WRITE) || (acc_kind == ACC_READ));

        if (is_fetch) begin
            st_d.fault  = |(exec_mask & slot_en);
            st_d.status = st_d.status | exec_mask;
        end

        eff_vld  = is_data ? 1'b1 : st_q.pend_vld;
        eff_mask = is_data ? data_mask : st_q.pend_mask;

        if (acc_done && eff_vld) begin
            st_d.trap      = |(eff_mask & slot_en);
            st_d.status    = st_d.status | eff_mask;
            st_d.pend_vld  = 1'b0;
            st_d.pend_mask = '0;
        end else if (is_data) begin
            st_d.pend_vld  = 1'b1;
            st_d.pend_mask = data_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault_req  = st_q.fault;
    assign trap_req   = st_q.trap;
    assign hit_status = st_q.status;

    a_r2_fault_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        fault_req |-> $past(acc_valid && (acc_kind == ACC_FETCH)));

    a_r7_trap_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(acc_done));

    a_r8_fault_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        fault_req |-> $past(|slot_en));

    a_r8_trap_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(|slot_en));

    a_r9_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(hit_status) & ~$past(hit_clr)) & ~hit_status) == '0);

endmodule

// File: rtl/dbg_bkpt_match.sv
module dbg_bkpt_match
    import bkpt_pkg::*;
#(
    parameter int NS = 4,
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NS*AW-1:0] cfg_addr,
    input  logic [2*NS-1:0]  cfg_type,
    input  logic [2*NS-1:0]  cfg_len,
    input  logic [NS-1:0]    cfg_en,
    input  logic             acc_valid,
    input  logic [1:0]       acc_kind,
    input  logic [AW-1:0]    acc_addr,
    input  logic [1:0]       acc_size,
    input  logic             acc_done,
    input  logic [NS-1:0]    hit_clr,
    output logic             fault_req,
    output logic             trap_req,
    output logic [NS-1:0]    hit_status
);

    logic [NS-1:0] exec_mask;
    logic [NS-1:0] data_mask;

    for (genvar i = 0; i < NS; i++) begin : g_slot
        bkpt_slot_cmp #(.AW(AW)) u_cmp (
            .bp_addr  (cfg_addr[i*AW +: AW]),
            .bp_type  (cfg_type[2*i +: 2]),
            .bp_len   (cfg_len[2*i +: 2]),
            .acc_kind (acc_kind),
            .acc_addr (acc_addr),
            .acc_size (acc_size),
            .exec_hit (exec_mask[i]),
            .data_hit (data_mask[i])
        );
    end

    bkpt_seq #(.NS(NS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_kind   (acc_kind),
        .acc_done   (acc_done),
        .exec_mask  (exec_mask),
        .data_mask  (data_mask),
        .slot_en    (cfg_en),
        .hit_clr    (hit_clr),
        .fault_req  (fault_req),
        .trap_req   (trap_req),
        .hit_status (hit_status)
    );

endmodule

// File: tb/sim_dbg_bkpt_match.sv
module sim_dbg_bkpt_match;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int AW = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NS*AW-1:0] cfg_addr;
    logic [2*NS-1:0]  cfg_type;
    logic [2*NS-1:0]  cfg_len;
    logic [NS-1:0]    cfg_en = '0;
    logic             acc_valid = 1'b0;
    logic [1:0]       acc_kind = 2'b11;
    logic [AW-1:0]    acc_addr = '0;
    logic [1:0]       acc_size = '0;
    logic             acc_done = 1'b0;
    logic [NS-1:0]    hit_clr = '0;
    logic             fault_req;
    logic             trap_req;
    logic [NS-1:0]    hit_status;

    logic [AW-1:0] c_addr [NS];
    logic [1:0]    c_type [NS];
    logic [1:0]    c_len  [NS];
    logic [NS-1:0] exp_st = '0;
    int nchk = 0;
    int nfail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < NS; i++) begin
            cfg_addr[i*AW +: AW] = c_addr[i];
            cfg_type[2*i +: 2]   = c_type[i];
            cfg_len[2*i +: 2]    = c_len[i];
        end
    end

    dbg_bkpt_match #(.NS(NS), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_type(cfg_type),
        .cfg_len(cfg_len), .cfg_en(cfg_en), .acc_valid(acc_valid),
        .acc_kind(acc_kind), .acc_addr(acc_addr), .acc_size(acc_size),
        .acc_done(acc_done), .hit_clr(hit_clr), .fault_req(fault_req),
        .trap_req(trap_req), .hit_status(hit_status)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    function automatic logic [NS-1:0] m_exec(input logic [1:0] k, input logic [AW-1:0] a);
        logic [NS-1:0] m = '0;
        for (int i = 0; i < NS; i++)
            m[i] = (k == 2'b00) && (c_type[i] == 2'b00) && (c_len[i] == 2'b00) && (a == c_addr[i]);
        return m;
    endfunction

    function automatic logic [NS-1:0] m_data(input logic [1:0] k, input logic [AW-1:0] a, input logic [1:0] sz);
        logic [NS-1:0] m = '0;
        for (int i = 0; i < NS; i++) begin
            int unsigned w;
            bit tok;
            logic [AW:0] base;
            w = (c_len[i] == 2'b00) ? 1 : (c_len[i] == 2'b01) ? 2 : (c_len[i] == 2'b11) ? 4 : 0;
            tok = (k == 2'b01 && (c_type[i] == 2'b01 || c_type[i] == 2'b11)) ||
                  (k == 2'b10 && c_type[i] == 2'b11);
            if (w != 0 && tok) begin
                base = {1'b0, c_addr[i]} - ({1'b0, c_addr[i]} % w);
                for (int b = 0; b <= int'(sz); b++) begin
                    logic [AW:0] ba;
                    ba = {1'b0, a} + (AW+1)'(b);
                    if (ba >= base && ba < base + (AW+1)'(w)) m[i] = 1'b1;
                end
            end
        end
        return m;
    endfunction

    task automatic set_slot(input int i, input logic [AW-1:0] a, input logic [1:0] t,
                            input logic [1:0] l, input bit en);
        c_addr[i] = a; c_type[i] = t; c_len[i] = l; cfg_en[i] = en;
    endtask

    task automatic do_fetch(input logic [AW-1:0] a, input string req);
        logic [NS-1:0] em;
        em = m_exec(2'b00, a);
        @(negedge clk);
        acc_valid = 1'b1; acc_kind = 2'b00; acc_addr = a; acc_size = 2'b00;
        @(negedge clk);
        acc_valid = 1'b0; acc_kind = 2'b11;
        exp_st = exp_st | em;
        chk(fault_req == |(em & cfg_en), req, 32'(fault_req), 32'(|(em & cfg_en)));
        chk(hit_status == exp_st, req, 32'(hit_status), 32'(exp_st));
    endtask

    task automatic do_data(input logic [1:0] k, input logic [AW-1:0] a, input logic [1:0] sz,
                           input int gap, input string req);
        logic [NS-1:0] dm;
        dm = m_data(k, a, sz);
        @(negedge clk);
        acc_valid = 1'b1; acc_kind = k; acc_addr = a; acc_size = sz; acc_done = (gap == 0);
        if (gap > 0) begin
            @(negedge clk);
            acc_valid = 1'b0; acc_kind = 2'b11;
            for (int g = 1; g < gap; g++) begin
                @(negedge clk);
                chk(trap_req == 1'b0, "R7 pending", 32'(trap_req), 32'd0);
            end
            acc_done = 1'b1;
        end
        @(negedge clk);
        acc_valid = 1'b0; acc_kind = 2'b11; acc_done = 1'b0;
        exp_st = exp_st | dm;
        chk(trap_req == |(dm & cfg_en), req, 32'(trap_req), 32'(|(dm & cfg_en)));
        chk(hit_status == exp_st, req, 32'(hit_status), 32'(exp_st));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [NS-1:0] dm;
        void'($urandom(32'd4242));
        for (int i = 0; i < NS; i++) set_slot(i, '0, 2'b10, 2'b10, 1'b0);

        repeat (3) @(negedge clk);
        chk(fault_req == 0 && trap_req == 0, "R1 reset req", {fault_req, trap_req}, 0);
        chk(hit_status == '0, "R1 reset status", 32'(hit_status), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hit_status == '0 && !fault_req && !trap_req, "R1 after reset", 32'(hit_status), 0);

        set_slot(0, 32'h2000, 2'b00, 2'b00, 1'b1);
        set_slot(1, 32'h3000, 2'b00, 2'b01, 1'b1);
        set_slot(2, 32'h4006, 2'b01, 2'b11, 1'b1);
        set_slot(3, 32'h5000, 2'b10, 2'b00, 1'b1);
        do_fetch(32'h2000, "R2 exact fetch");
        chk(fault_req == 1'b1, "R2 fault seen", 32'(fault_req), 1);
        @(negedge clk);
        chk(fault_req == 1'b0, "R2 one-cycle fault", 32'(fault_req), 0);
        do_fetch(32'h2001, "R2 next byte");
        do_fetch(32'h1fff, "R2 prev byte");
        do_fetch(32'h3000, "R3 exec bad len");
        do_data(2'b10, 32'h2000, 2'b11, 0, "R6 data vs exec slot");
        do_data(2'b01, 32'h4003, 2'b01, 0, "R5 straddle low edge");
        chk(trap_req == 1'b1, "R5 trap seen", 32'(trap_req), 1);
        do_data(2'b01, 32'h4002, 2'b01, 0, "R5 just below window");
        do_data(2'b01, 32'h4008, 2'b00, 0, "R4 just above window");
        do_data(2'b10, 32'h4004, 2'b00, 0, "R6 read on write-only");
        do_fetch(32'h4006, "R6 fetch on data slot");
        do_data(2'b01, 32'h5000, 2'b00, 0, "R6 type 10 reserved");
        set_slot(3, 32'h5000, 2'b11, 2'b10, 1'b1);
        do_data(2'b10, 32'h5000, 2'b11, 0, "R4 length 10 reserved");
        set_slot(3, 32'h5003, 2'b11, 2'b01, 1'b1);
        do_data(2'b10, 32'h5002, 2'b00, 0, "R4 len 2 aligned low");
        do_data(2'b10, 32'h5004, 2'b00, 0, "R4 len 2 above");
        set_slot(3, 32'h0000_0001, 2'b11, 2'b11, 1'b1);
        do_data(2'b01, 32'hffff_ffff, 2'b11, 0, "R5 no wraparound");
        do_data(2'b01, 32'hffff_fffe, 2'b11, 0, "R5 top of space");

        cfg_en[2] = 1'b0;
        do_data(2'b01, 32'h4005, 2'b00, 0, "R8 disabled slot no trap");
        cfg_en[0] = 1'b0;
        do_fetch(32'h2000, "R8 disabled slot no fault");
        cfg_en = '1;

        @(negedge clk);
        hit_clr = 4'b0001;
        acc_valid = 1'b1; acc_kind = 2'b00; acc_addr = 32'h2000;
        @(negedge clk);
        hit_clr = '0; acc_valid = 1'b0; acc_kind = 2'b11;
        chk(hit_status[0] == 1'b1, "R9 set wins over clear", 32'(hit_status), 32'(exp_st));
        hit_clr = '1;
        @(negedge clk);
        hit_clr = '0;
        exp_st = '0;
        chk(hit_status == '0, "R9 clear", 32'(hit_status), 0);

        @(negedge clk);
        acc_valid = 1'b1; acc_kind = 2'b11; acc_addr = 32'h2000; acc_done = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0; acc_done = 1'b0;
        chk(!fault_req && !trap_req && hit_status == '0, "R10 kind 11 ignored",
            {fault_req, trap_req, 2'b00, hit_status}, 0);

        do_data(2'b01, 32'h4004, 2'b00, 4, "R7 delayed completion");
        do_data(2'b11, 32'h4004, 2'b00, 0, "R10 kind 11 data ignored");

        dm = m_data(2'b10, 32'h9000, 2'b00);
        @(negedge clk);
        acc_valid = 1'b1; acc_kind = 2'b01; acc_addr = 32'h4004; acc_size = 2'b00;
        @(negedge clk);
        acc_kind = 2'b10; acc_addr = 32'h9000;
        @(negedge clk);
        acc_valid = 1'b0; acc_kind = 2'b11; acc_done = 1'b1;
        @(negedge clk);
        acc_done = 1'b0;
        exp_st = exp_st | dm;
        chk(trap_req == 1'b0, "R7 newer access replaces", 32'(trap_req), 0);
        chk(hit_status == exp_st, "R7 replaced status", 32'(hit_status), 32'(exp_st));

        @(negedge clk);
        acc_done = 1'b1;
        @(negedge clk);
        acc_done = 1'b0;
        chk(trap_req == 1'b0, "R7 done without pending", 32'(trap_req), 0);

        for (int it = 0; it < 400; it++) begin
            int op;
            logic [AW-1:0] a;
            if (it % 25 == 0) begin
                for (int i = 0; i < NS; i++)
                    set_slot(i, 32'h1000 + ($urandom % 48), 2'($urandom), 2'($urandom), 1'($urandom));
                hit_clr = '1;
                @(negedge clk);
                hit_clr = '0;
                exp_st = '0;
            end
            a = 32'h1000 + ($urandom % 52);
            if ($urandom % 3 == 0) a = c_addr[$urandom % NS];
            op = $urandom % 3;
            if (op == 0) do_fetch(a, "R2 R3 random fetch");
            else do_data(2'(op), a, 2'($urandom), $urandom % 3, "R4 R5 R6 R7 random data");
        end

        summary();
        $finish;
    end

endmodule